// File: doc/BRIEF.md
# Halt and Wake-Up Controller

This block governs the low-power halt state of a small processor core. When the core reports that it has executed its halt instruction, the controller captures a 2-bit halt-mode selection. From then on it drives separate clock-enable outputs for the core, for a group of peripherals, for the always-on logic and for the oscillator. A selection of 00 means "no halt", and such a request is dropped.

While halted, the controller watches three kinds of wake source:

- a set of prioritised interrupt requests, each carrying a 3-bit level;
- a non-maskable request;
- a fixed subset of sources that is wired to wake the core even when masked.

Once it decides to leave halt, it returns the core to running and reports two things. The first is whether the interrupt should be handed to the core. The second is whether the request flag must stay pending. In the deepest mode the oscillator has been stopped, so a programmable warm-up interval runs before the core clock comes back. Reset aborts any halt state at once.

The controller is built as an explicit state machine with three states: RUN, HALTED and WARMUP. It also contains a wake evaluator, a warm-up down-counter and a clock-enable decoder.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While reset is asserted and afterwards, the controller is running: cpu_clk_en, aon_clk_en and osc_en are 1, periph_clk_en is all ones, and halted, wake_done, wake_service and wake_keep_flag are 0.
- R2: A halt_req sampled while halt_mode is 00 is ignored, and the core stays running. A halt_req sampled while already halted or warming up is also ignored.
- R3: A halt_req with a nonzero halt_mode, sampled while running, sets halted and clears cpu_clk_en from the next cycle. The mode and the periph_sel value are captured at that edge. Both stay fixed until the controller is running again, whatever the inputs do meanwhile.
- R4: In mode 11 (light idle), periph_clk_en equals the periph_sel value captured at entry. aon_clk_en and osc_en stay 1.
- R5: In mode 10 (deep idle), periph_clk_en is all zero. aon_clk_en and osc_en stay 1.
- R6: In mode 01 (stop), every enable is 0: cpu, peripherals, always-on and oscillator.
- R7: A maskable request on source i, with its level at irq_lvl[3*i+2:3*i], releases halt only when that level is strictly greater than int_mask. A request whose level is equal to or below int_mask keeps the core halted, unless R9 applies.
- R8: nmi_req releases halt for any int_mask value, and the release is reported with wake_service = 1.
- R9: A source whose bit is set in WAKE_SRC (default: sources 4 to 7) releases halt even when its level does not exceed int_mask. If no serviceable request is present at the same time, the release is reported with wake_service = 0 and wake_keep_flag = 1.
- R10: Releasing a light or deep idle takes effect on the edge that samples the wake request. From the following cycle cpu_clk_en is 1, and wake_done is high for exactly one cycle, qualifying wake_service and wake_keep_flag.
- R11: Releasing stop enters a warm-up phase of warm_count+1 cycles. In that phase osc_en is 1 and cpu_clk_en is 0. In the cycle after the phase, cpu_clk_en returns to 1 and wake_done pulses.
- R12: Asserting rst_n low releases any halt or warm-up state at once. The outputs take their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Core has executed its halt instruction |
| halt_mode | input | 2 | Requested mode: 00 none, 01 stop, 10 deep idle, 11 light idle |
| periph_sel | input | NUM_PERIPH | Per-peripheral run selection used in light idle |
| int_mask | input | LVL_W | Current interrupt mask level |
| irq_req | input | NUM_SRC | Maskable interrupt request lines |
| irq_lvl | input | NUM_SRC*LVL_W | Packed request levels, source i at bits [LVL_W*i +: LVL_W] |
| nmi_req | input | 1 | Non-maskable request |
| warm_count | input | WARM_W | Oscillator warm-up length minus one, in cycles |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | NUM_PERIPH | Peripheral clock enables |
| aon_clk_en | output | 1 | Always-on domain clock enable |
| osc_en | output | 1 | Oscillator enable |
| halted | output | 1 | Core is not running (halted or warming up) |
| wake_done | output | 1 | One-cycle pulse when the core resumes after an interrupt release |
| wake_service | output | 1 | With wake_done: the interrupt is to be serviced |
| wake_keep_flag | output | 1 | With wake_done: released by a masked wake-capable source, so the flag stays set |

## Verification
The bench presents a request whose level equals the mask and checks that the core stays halted. A controller using a non-strict compare would wake there. Next the bench raises a masked wake-capable source and expects a release with the keep-flag set and service clear. A design that either ignored those sources or serviced them would show up in the scoreboard. Reprogramming periph_sel and raising a second halt request while in light idle exposes a controller that fails to latch its mode or peripheral selection. Counting the exact warm-up cycles after a stop release catches off-by-one errors in the counter, and an asynchronous reset during stop must restore every enable without waiting for a clock edge.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'b00,
        MODE_STOP  = 2'b01,
        MODE_IDLE1 = 2'b10,
        MODE_IDLE2 = 2'b11
    } halt_mode_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_HALTED = 2'b01,
        ST_WARMUP = 2'b10
    } ctl_state_e;

endpackage

// File: rtl/hw_wake_eval.sv
module hw_wake_eval #(
    parameter int                   NUM_SRC  = 8,
    parameter int                   LVL_W    = 3,
    parameter logic [NUM_SRC-1:0]   WAKE_SRC = 8'hF0
) (
    input  logic [NUM_SRC-1:0]       irq_req,
    input  logic [NUM_SRC*LVL_W-1:0] irq_lvl,
    input  logic [LVL_W-1:0]         int_mask,
    input  logic                     nmi_req,
    output logic                     wake_any,
    output logic                     wake_service,
    output logic                     wake_keep
);

    logic [NUM_SRC-1:0] above_mask;
    logic [NUM_SRC-1:0] pinned_wake;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign above_mask[i]  = irq_req[i] && (irq_lvl[i*LVL_W +: LVL_W] > int_mask);
        assign pinned_wake[i] = irq_req[i] && WAKE_SRC[i];
    end

    always_comb begin
        wake_service = nmi_req || (|above_mask);
        wake_keep    = !wake_service && (|pinned_wake);
        wake_any     = wake_service || wake_keep;
    end

endmodule

// File: rtl/hw_warmup_cnt.sv
module hw_warmup_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R11: warm-up counts down by exactly one per running cycle
    assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/hw_clk_en_dec.sv
module hw_clk_en_dec
    import halt_wake_pkg::*;
#(
    parameter int NUM_PERIPH = 4
) (
    input  ctl_state_e            state,
    input  halt_mode_e            mode,
    input  logic [NUM_PERIPH-1:0] psel,
    output logic                  cpu_clk_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic                  aon_clk_en,
    output logic                  osc_en
);

    always_comb begin
        cpu_clk_en    = 1'b1;
        periph_clk_en = '1;
        aon_clk_en    = 1'b1;
        osc_en        = 1'b1;
        unique case (state)
            ST_HALTED: begin
                cpu_clk_en = 1'b0;
                unique case (mode)
                    MODE_IDLE2: periph_clk_en = psel;
                    MODE_IDLE1: periph_clk_en = '0;
                    MODE_STOP: begin
                        periph_clk_en = '0;
                        aon_clk_en    = 1'b0;
                        osc_en        = 1'b0;
                    end
                    default: periph_clk_en = '1;
                endcase
            end
            ST_WARMUP: begin
                cpu_clk_en    = 1'b0;
                periph_clk_en = '0;
                aon_clk_en    = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import halt_wake_pkg::*;
#(
    parameter int                 NUM_SRC    = 8,
    parameter int                 LVL_W      = 3,
    parameter int                 NUM_PERIPH = 4,
    parameter int                 WARM_W     = 8,
    parameter logic [NUM_SRC-1:0] WAKE_SRC   = 8'hF0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     halt_req,
    input  logic [1:0]               halt_mode,
    input  logic [NUM_PERIPH-1:0]    periph_sel,
    input  logic [LVL_W-1:0]         int_mask,
    input  logic [NUM_SRC-1:0]       irq_req,
    input  logic [NUM_SRC*LVL_W-1:0] irq_lvl,
    input  logic                     nmi_req,
    input  logic [WARM_W-1:0]        warm_count,
    output logic                     cpu_clk_en,
    output logic [NUM_PERIPH-1:0]    periph_clk_en,
    output logic                     aon_clk_en,
    output logic                     osc_en,
    output logic                     halted,
    output logic                     wake_done,
    output logic                     wake_service,
    output logic                     wake_keep_flag
);

    typedef struct packed {
        ctl_state_e            state;
        halt_mode_e            mode;
        logic [NUM_PERIPH-1:0] psel;
        logic                  svc;
        logic                  keep;
        logic                  done;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic wake_any, wake_svc_c, wake_keep_c;
    logic warm_load, warm_run, warm_expired;

    hw_wake_eval #(
        .NUM_SRC  (NUM_SRC),
        .LVL_W    (LVL_W),
        .WAKE_SRC (WAKE_SRC)
    ) u_wake (
        .irq_req      (irq_req),
        .irq_lvl      (irq_lvl),
        .int_mask     (int_mask),
        .nmi_req      (nmi_req),
        .wake_any     (wake_any),
        .wake_service (wake_svc_c),
        .wake_keep    (wake_keep_c)
    );

    assign warm_load = (r_q.state == ST_HALTED) && wake_any && (r_q.mode == MODE_STOP);
    assign warm_run  = (r_q.state == ST_WARMUP);

    hw_warmup_cnt #(
        .CNT_W (WARM_W)
    ) u_warm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (warm_load),
        .load_val (warm_count),
        .run      (warm_run),
        .expired  (warm_expired)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_RUN: begin
                if (halt_req && halt_mode != MODE_NONE) begin
                    r_d.state = ST_HALTED;
                    r_d.mode  = halt_mode_e'(halt_mode);
                    r_d.psel  = periph_sel;
                end
            end
            ST_HALTED: begin
                if (wake_any) begin
                    r_d.svc  = wake_svc_c;
                    r_d.keep = wake_keep_c;
                    if (r_q.mode == MODE_STOP) begin
                        r_d.state = ST_WARMUP;
                    end else begin
                        r_d.state = ST_RUN;
                        r_d.done  = 1'b1;
                    end
                end
            end
            ST_WARMUP: begin
                if (warm_expired) begin
                    r_d.state = ST_RUN;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_RUN;
            r_q.mode  <= MODE_NONE;
            r_q.psel  <= '0;
            r_q.svc   <= 1'b0;
            r_q.keep  <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    hw_clk_en_dec #(
        .NUM_PERIPH (NUM_PERIPH)
    ) u_dec (
        .state         (r_q.state),
        .mode          (r_q.mode),
        .psel          (r_q.psel),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .aon_clk_en    (aon_clk_en),
        .osc_en        (osc_en)
    );

    assign halted         = (r_q.state != ST_RUN);
    assign wake_done      = r_q.done;
    assign wake_service   = r_q.done && r_q.svc;
    assign wake_keep_flag = r_q.done && r_q.keep;

    // R2: a halt request carrying mode 00 leaves the core running
    assert_mode_none_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && halt_req && halt_mode == 2'b00) |=> (r_q.state == ST_RUN));

    // R3: the latched mode stays fixed while away from RUN
    assert_mode_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_RUN && $past(r_q.state) != ST_RUN) |-> $stable(r_q.mode));

    // R6: stop shuts every domain including the oscillator
    assert_stop_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HALTED && r_q.mode == MODE_STOP)
            |-> (!osc_en && !aon_clk_en && !cpu_clk_en && periph_clk_en == '0));

    // R8: a non-maskable request always leaves the halted state
    assert_nmi_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HALTED && nmi_req) |=> (r_q.state != ST_HALTED));

    // R10: the wake pulse coincides with the core clock being back
    assert_done_with_cpu_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |-> (cpu_clk_en && !halted));

    // R11: during warm-up the oscillator runs but the core stays gated
    assert_warm_gating_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WARMUP) |-> (osc_en && !cpu_clk_en));

endmodule

// File: tb/halt_wake_ctrl_tb.sv
`timescale 1ns/1ps
module halt_wake_ctrl_tb;

    localparam int NUM_SRC    = 8;
    localparam int LVL_W      = 3;
    localparam int NUM_PERIPH = 4;
    localparam int WARM_W     = 8;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     halt_req = 1'b0;
    logic [1:0]               halt_mode = 2'b00;
    logic [NUM_PERIPH-1:0]    periph_sel = '0;
    logic [LVL_W-1:0]         int_mask = '0;
    logic [NUM_SRC-1:0]       irq_req = '0;
    logic [NUM_SRC*LVL_W-1:0] irq_lvl = '0;
    logic                     nmi_req = 1'b0;
    logic [WARM_W-1:0]        warm_count = '0;
    logic                     cpu_clk_en, aon_clk_en, osc_en, halted;
    logic                     wake_done, wake_service, wake_keep_flag;
    logic [NUM_PERIPH-1:0]    periph_clk_en;

    int checks = 0;
    int errors = 0;

    typedef struct { bit svc; bit keep; } wake_item_t;
    wake_item_t exp_q[$];

    always #4 clk = ~clk;

    halt_wake_ctrl #(
        .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .NUM_PERIPH(NUM_PERIPH),
        .WARM_W(WARM_W), .WAKE_SRC(8'hF0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_mode(halt_mode),
        .periph_sel(periph_sel), .int_mask(int_mask), .irq_req(irq_req),
        .irq_lvl(irq_lvl), .nmi_req(nmi_req), .warm_count(warm_count),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .aon_clk_en(aon_clk_en), .osc_en(osc_en), .halted(halted),
        .wake_done(wake_done), .wake_service(wake_service),
        .wake_keep_flag(wake_keep_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_wake(input bit svc, input bit keep);
        wake_item_t it;
        it.svc  = svc;
        it.keep = keep;
        exp_q.push_back(it);
    endtask

    task automatic enter_halt(input logic [1:0] mode, input logic [NUM_PERIPH-1:0] sel);
        @(negedge clk);
        halt_req   = 1'b1;
        halt_mode  = mode;
        periph_sel = sel;
        @(negedge clk);
        halt_req   = 1'b0;
        chk("R3 halted", halted, 1);
        chk("R3 cpu_clk_en", cpu_clk_en, 0);
    endtask

    // scoreboard monitor: each wake pulse must match the next expected item
    always @(negedge clk) begin
        if (rst_n && wake_done) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10 unexpected wake_done actual 1 expected 0");
            end else begin
                wake_item_t it;
                it = exp_q.pop_front();
                chk("R8/R9 wake_service", wake_service, it.svc);
                chk("R9 wake_keep_flag", wake_keep_flag, it.keep);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1 cpu_clk_en in reset", cpu_clk_en, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cpu_clk_en", cpu_clk_en, 1);
        chk("R1 periph_clk_en", periph_clk_en, 4'hF);
        chk("R1 aon_clk_en", aon_clk_en, 1);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 halted", halted, 0);
        chk("R1 wake_done", wake_done, 0);

        // R2: mode 00 request dropped
        halt_req  = 1'b1;
        halt_mode = 2'b00;
        @(negedge clk);
        halt_req  = 1'b0;
        chk("R2 halted", halted, 0);
        chk("R2 cpu_clk_en", cpu_clk_en, 1);

        // R4: light idle with captured peripheral selection
        enter_halt(2'b11, 4'b1010);
        chk("R4 periph_clk_en", periph_clk_en, 4'b1010);
        chk("R4 osc_en", osc_en, 1);
        chk("R4 aon_clk_en", aon_clk_en, 1);
        // R3/R2: changes after entry have no effect
        periph_sel = 4'b0101;
        halt_req   = 1'b1;
        halt_mode  = 2'b01;
        @(negedge clk);
        halt_req   = 1'b0;
        chk("R3 periph held", periph_clk_en, 4'b1010);
        chk("R3 mode held osc_en", osc_en, 1);

        // R7: level equal to mask keeps halt
        int_mask = 3'd3;
        irq_lvl  = '0;
        irq_lvl[0*LVL_W +: LVL_W] = 3'd3;
        irq_req  = 8'h01;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7 equal level stays halted", halted, 1);
        end
        // R7/R10: level above mask releases next edge
        expect_wake(1'b1, 1'b0);
        irq_lvl[0*LVL_W +: LVL_W] = 3'd4;
        @(negedge clk);
        irq_req = '0;
        chk("R10 cpu_clk_en after wake", cpu_clk_en, 1);
        chk("R10 wake_done", wake_done, 1);
        @(negedge clk);
        chk("R10 wake_done one cycle", wake_done, 0);

        // R5: deep idle
        enter_halt(2'b10, 4'b1111);
        chk("R5 periph_clk_en", periph_clk_en, 0);
        chk("R5 aon_clk_en", aon_clk_en, 1);
        chk("R5 osc_en", osc_en, 1);

        // R9: masked wake-capable source 5 releases with flag kept
        int_mask = 3'd5;
        irq_lvl  = '0;
        irq_lvl[5*LVL_W +: LVL_W] = 3'd1;
        expect_wake(1'b0, 1'b1);
        irq_req = 8'h20;
        @(negedge clk);
        irq_req = '0;
        chk("R9 cpu_clk_en", cpu_clk_en, 1);
        chk("R9 wake_done", wake_done, 1);

        // R6: stop
        enter_halt(2'b01, 4'b1111);
        chk("R6 osc_en", osc_en, 0);
        chk("R6 aon_clk_en", aon_clk_en, 0);
        chk("R6 periph_clk_en", periph_clk_en, 0);

        // R8/R11: NMI with full mask, warm-up of 4 cycles
        int_mask   = 3'd7;
        warm_count = 8'd3;
        expect_wake(1'b1, 1'b0);
        nmi_req    = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            nmi_req = 1'b0;
            chk("R11 warm-up cpu_clk_en", cpu_clk_en, 0);
            chk("R11 warm-up osc_en", osc_en, 1);
        end
        @(negedge clk);
        chk("R11 cpu_clk_en after warm-up", cpu_clk_en, 1);
        chk("R11 wake_done after warm-up", wake_done, 1);

        // R12: reset during stop
        enter_halt(2'b01, 4'b0000);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R12 cpu_clk_en", cpu_clk_en, 1);
        chk("R12 osc_en", osc_en, 1);
        chk("R12 halted", halted, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 halted after reset", halted, 0);
        chk("R12 periph_clk_en", periph_clk_en, 4'hF);

        chk("R10 scoreboard drained", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule